// File: doc/BRIEF.md
# Synchronous Rectifier Gate Sequencer

This block decides, one clock at a time, whether the gate of a synchronous rectifier switch on the secondary side of a flyback converter should be driven. Each cycle it takes a signed digital sample of the switch's drain-to-source voltage and a digital supply code. It turns the gate on when the body diode starts to conduct. It keeps the gate on for a programmable minimum on time, so that ringing at turn-on cannot cut the pulse short. It turns the gate off once the voltage rises close to zero.

After each turn-off, a fixed blanking window keeps a leftover body-diode drop from firing the gate again. The window closes early when the voltage swings well positive. This lets the same sequencer serve continuous, discontinuous and critical conduction. A supply lockout with hysteresis and an enable-driven sleep state keep the gate off whenever the controller should not switch.

The voltage input has no handshake and applies no back-pressure: a new sample is consumed on every rising clock edge, and the producer must hold a valid code there at all times.

Top module: `sr_gate_ctrl`

## Requirements
- R1: With all thresholds at their defaults (voltage LSB 0.5 mV), the gate turns on one clock after an armed cycle sees `vds_i < -100`. A sample of exactly -100 does not turn it on.
- R2: Once the gate is on, it stays on for at least `max(mot_cycles_i,1)` clock cycles, whatever the voltage does, unless supply lockout or sleep intervenes.
- R3: After the minimum on time, the gate turns off one clock after `vds_i` exceeds the off threshold picked by `off_sel_i`: 0 gives -7, 1 gives -21, 2 gives -38, and 3 behaves like 0. A sample equal to the threshold keeps the gate on.
- R4: If the voltage is already above the off threshold when the minimum on time ends, the gate pulse lasts exactly `max(mot_cycles_i,1)` cycles.
- R5: After a turn-off, turn-on requests are ignored for `BLANK_CYC` cycles. With a low voltage held throughout, the gate rises `BLANK_CYC+1` clocks after the turn-off edge.
- R6: During blanking, a sample `vds_i > 5000` re-arms the sequencer on the next clock. A sample of exactly 5000 does not re-arm it.
- R7: After reset, the sequencer stays in lockout with the gate low until a cycle sees both `vsup_i > 105` and `en_i` high. It arms on that cycle and can turn on no earlier than the following clock.
- R8: In any state, `vsup_i < 90` forces lockout and a low gate on the next clock. A code of 90 does not.
- R9: A low `en_i` outside lockout forces sleep and a low gate on the next clock. The sequencer stays asleep until `en_i` returns high, and then it arms.
- R10: While `rst_n` is low, the gate is low and the sequencer is in lockout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vds_i | input | VW (16) | Signed drain-to-source sample, 0.5 mV per LSB |
| vsup_i | input | SW (8) | Unsigned supply code, 0.1 V per LSB |
| en_i | input | 1 | Enable; low selects sleep |
| off_sel_i | input | 2 | Turn-off threshold select |
| mot_cycles_i | input | CW (10) | Minimum on time in clock cycles |
| gate_o | output | 1 | Registered gate-enable |

## Verification
The checker assumes `mot_cycles_i` holds steady while the gate is on, because it latches the value at turn-on and compares the pulse length against it. It also assumes that `vds_i`, `vsup_i` and `en_i` are settled at each rising edge. The bench drives every input on the falling edge and changes `mot_cycles_i` only while the gate is low. The minimum-on-time check excuses pulses that end because of lockout or sleep. The stimulus exercises both of those exits on purpose.

// File: rtl/sr_gate_pkg.sv
package sr_gate_pkg;
  typedef enum logic [2:0] {
    ST_LOCKOUT = 3'd0,
    ST_SLEEP   = 3'd1,
    ST_ARMED   = 3'd2,
    ST_ON_MOT  = 3'd3,
    ST_ON      = 3'd4,
    ST_BLANK   = 3'd5
  } sr_state_t;

  function automatic logic gate_on_state(sr_state_t s);
    return (s == ST_ON_MOT) || (s == ST_ON);
  endfunction
endpackage

// File: rtl/sr_vds_compare.sv
module sr_vds_compare #(
  parameter int VW     = 16,
  parameter int ON_TH  = -100,
  parameter int OFF_T0 = -7,
  parameter int OFF_T1 = -21,
  parameter int OFF_T2 = -38,
  parameter int RST_TH = 5000
) (
  input  logic signed [VW-1:0] vds,
  input  logic [1:0]           sel,
  output logic                 below_on,
  output logic                 above_off,
  output logic                 above_rst
);
  localparam logic signed [VW-1:0] ON_V  = ON_TH[VW-1:0];
  localparam logic signed [VW-1:0] RST_V = RST_TH[VW-1:0];
  localparam logic signed [VW-1:0] OFF_V0 = OFF_T0[VW-1:0];
  localparam logic signed [VW-1:0] OFF_V1 = OFF_T1[VW-1:0];
  localparam logic signed [VW-1:0] OFF_V2 = OFF_T2[VW-1:0];

  logic signed [VW-1:0] off_v;

  always_comb begin
    case (sel)
      2'd1:    off_v = OFF_V1;
      2'd2:    off_v = OFF_V2;
      default: off_v = OFF_V0;
    endcase
  end

  assign below_on  = vds < ON_V;
  assign above_off = vds > off_v;
  assign above_rst = vds > RST_V;
endmodule

// File: rtl/sr_supply_compare.sv
module sr_supply_compare #(
  parameter int SW     = 8,
  parameter int ON_LVL = 105,
  parameter int UV_LVL = 90
) (
  input  logic [SW-1:0] vsup,
  output logic          sup_high,
  output logic          sup_low
);
  localparam logic [SW-1:0] ON_C = ON_LVL[SW-1:0];
  localparam logic [SW-1:0] UV_C = UV_LVL[SW-1:0];

  assign sup_high = vsup > ON_C;
  assign sup_low  = vsup < UV_C;
endmodule

// File: rtl/sr_down_timer.sv
module sr_down_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         run,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (load)
      cnt_q <= load_val;
    else if (run && (cnt_q > W'(1)))
      cnt_q <= cnt_q - W'(1);
  end

  assign expired = cnt_q <= W'(1);
endmodule

// File: rtl/sr_gate_ctrl.sv
module sr_gate_ctrl #(
  parameter int VW        = 16,
  parameter int SW        = 8,
  parameter int CW        = 10,
  parameter int BLANK_CYC = 1500,
  parameter int ON_TH     = -100,
  parameter int OFF_T0    = -7,
  parameter int OFF_T1    = -21,
  parameter int OFF_T2    = -38,
  parameter int RST_TH    = 5000,
  parameter int ON_LVL    = 105,
  parameter int UV_LVL    = 90
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [VW-1:0] vds_i,
  input  logic [SW-1:0]        vsup_i,
  input  logic                 en_i,
  input  logic [1:0]           off_sel_i,
  input  logic [CW-1:0]        mot_cycles_i,
  output logic                 gate_o
);
  import sr_gate_pkg::*;

  localparam int BW = $clog2(BLANK_CYC + 1) + 1;
  localparam logic [BW-1:0] BLANK_LD = BLANK_CYC[BW-1:0];

  sr_state_t st_q, st_d;
  logic below_on, above_off, above_rst;
  logic sup_high, sup_low;
  logic ld_mot, ld_blk, mot_done, blk_done;
  logic gate_q;

  sr_vds_compare #(
    .VW(VW), .ON_TH(ON_TH), .OFF_T0(OFF_T0), .OFF_T1(OFF_T1),
    .OFF_T2(OFF_T2), .RST_TH(RST_TH)
  ) u_vcmp (
    .vds(vds_i), .sel(off_sel_i), .below_on(below_on),
    .above_off(above_off), .above_rst(above_rst)
  );

  sr_supply_compare #(.SW(SW), .ON_LVL(ON_LVL), .UV_LVL(UV_LVL)) u_scmp (
    .vsup(vsup_i), .sup_high(sup_high), .sup_low(sup_low)
  );

  sr_down_timer #(.W(CW)) u_mot (
    .clk(clk), .rst_n(rst_n), .load(ld_mot), .load_val(mot_cycles_i),
    .run(st_q == ST_ON_MOT), .expired(mot_done)
  );

  sr_down_timer #(.W(BW)) u_blk (
    .clk(clk), .rst_n(rst_n), .load(ld_blk), .load_val(BLANK_LD),
    .run(st_q == ST_BLANK), .expired(blk_done)
  );

  always_comb begin
    st_d   = st_q;
    ld_mot = 1'b0;
    ld_blk = 1'b0;
    if (sup_low) begin
      st_d = ST_LOCKOUT;
    end else if (st_q == ST_LOCKOUT) begin
      if (sup_high && en_i) st_d = ST_ARMED;
    end else if (!en_i) begin
      st_d = ST_SLEEP;
    end else begin
      case (st_q)
        ST_SLEEP: st_d = ST_ARMED;
        ST_ARMED: begin
          if (below_on) begin
            st_d   = ST_ON_MOT;
            ld_mot = 1'b1;
          end
        end
        ST_ON_MOT: begin
          if (mot_done) begin
            if (above_off) begin
              st_d   = ST_BLANK;
              ld_blk = 1'b1;
            end else begin
              st_d = ST_ON;
            end
          end
        end
        ST_ON: begin
          if (above_off) begin
            st_d   = ST_BLANK;
            ld_blk = 1'b1;
          end
        end
        ST_BLANK: begin
          if (above_rst || blk_done) st_d = ST_ARMED;
        end
        default: st_d = ST_LOCKOUT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_LOCKOUT;
      gate_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      gate_q <= gate_on_state(st_d);
    end
  end

  assign gate_o = gate_q;
endmodule

// File: rtl/sr_gate_chk.sv
module sr_gate_chk #(
  parameter int VW     = 16,
  parameter int SW     = 8,
  parameter int CW     = 10,
  parameter int ON_TH  = -100,
  parameter int UV_LVL = 90
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic signed [VW-1:0] vds_i,
  input logic [SW-1:0]        vsup_i,
  input logic                 en_i,
  input logic [CW-1:0]        mot_cycles_i,
  input logic                 gate_o
);
  localparam logic signed [VW-1:0] ON_V = ON_TH[VW-1:0];
  localparam logic [SW-1:0]        UV_C = UV_LVL[SW-1:0];

  int unsigned   hi_run;
  logic [CW-1:0] mot_lat;
  int unsigned   mot_need;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run  <= 0;
      mot_lat <= '0;
    end else begin
      hi_run <= gate_o ? hi_run + 1 : 0;
      if (!gate_o) mot_lat <= mot_cycles_i;
    end
  end

  assign mot_need = (mot_lat == '0) ? 1 : int'(mot_lat);

  // R1
  gate_rise_low_vds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_o) |-> ($past(vds_i) < ON_V));

  // R2
  min_on_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(gate_o) && $past(en_i) && ($past(vsup_i) >= UV_C)) |-> (hi_run >= mot_need));

  // R8
  undervolt_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vsup_i < UV_C) |=> !gate_o);

  // R9
  sleep_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !gate_o);

  // R10
  always @(posedge clk) begin
    if (!rst_n) reset_gate_low_chk: assert (!gate_o);
  end
endmodule

bind sr_gate_ctrl sr_gate_chk #(
  .VW(VW), .SW(SW), .CW(CW), .ON_TH(ON_TH), .UV_LVL(UV_LVL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .vds_i(vds_i), .vsup_i(vsup_i), .en_i(en_i),
  .mot_cycles_i(mot_cycles_i), .gate_o(gate_o)
);

// File: tb/tb_sr_gate_ctrl.sv
module tb_sr_gate_ctrl;
  localparam int VW = 16;
  localparam int SW = 8;
  localparam int CW = 10;
  localparam int BLK = 40;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic signed [VW-1:0] vds;
  logic [SW-1:0]        vsup;
  logic                 en;
  logic [1:0]           sel;
  logic [CW-1:0]        mot;
  logic                 gate;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  sr_gate_ctrl #(.VW(VW), .SW(SW), .CW(CW), .BLANK_CYC(BLK)) dut (
    .clk(clk), .rst_n(rst_n), .vds_i(vds), .vsup_i(vsup), .en_i(en),
    .off_sel_i(sel), .mot_cycles_i(mot), .gate_o(gate)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    vds = '0; vsup = '0; en = 1'b0; sel = 2'd0; mot = CW'(4);
    ticks(2);
    rst_n = 1'b1;
  endtask

  task automatic arm_and_fire();
    vsup = 8'd120; en = 1'b1; vds = 16'sd0;
    tick();
    vds = -16'sd200;
    tick();
  endtask

  task automatic wait_gate_low();
    for (int i = 0; i < 20; i++) begin
      if (!gate) break;
      tick();
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    vds = -16'sd200; vsup = 8'd120; en = 1'b1; sel = 2'd0; mot = CW'(4);
    ticks(2);
    check("R10 gate during reset", gate, 0);
    rst_n = 1'b1;
    check("R10 gate after release", gate, 0);
  endtask

  task automatic t_lockout();
    do_reset();
    vsup = 8'd100; en = 1'b1; vds = -16'sd200;
    ticks(3);
    check("R7 supply between levels", gate, 0);
    vsup = 8'd105;
    ticks(2);
    check("R7 supply at on level", gate, 0);
    vsup = 8'd106;
    tick();
    check("R7 arming cycle", gate, 0);
    tick();
    check("R7 fires after arming", gate, 1);
    do_reset();
    vsup = 8'd120; en = 1'b0; vds = -16'sd200;
    ticks(3);
    check("R7 enable low holds lockout", gate, 0);
    en = 1'b1;
    tick();
    check("R7 arming with enable", gate, 0);
    tick();
    check("R7 fires with enable", gate, 1);
  endtask

  task automatic t_turn_on();
    do_reset();
    vsup = 8'd120; en = 1'b1; vds = -16'sd100;
    ticks(3);
    check("R1 at threshold no turn-on", gate, 0);
    vds = -16'sd101;
    tick();
    check("R1 below threshold turns on", gate, 1);
  endtask

  task automatic pulse_len(int m, string req);
    int n;
    do_reset();
    mot = CW'(m);
    arm_and_fire();
    vds = 16'sd500;
    n = 0;
    for (int i = 0; i < 60; i++) begin
      if (!gate) break;
      n++;
      tick();
    end
    check(req, n, (m == 0) ? 1 : m);
  endtask

  task automatic t_mot();
    pulse_len(10, "R2 R4 hold for ten cycles");
    pulse_len(0, "R4 zero count gives one cycle");
    pulse_len(3, "R4 three cycle pulse");
  endtask

  task automatic off_case(logic [1:0] s, int stay, int go);
    do_reset();
    sel = s; mot = CW'(2);
    arm_and_fire();
    vds = 16'(stay);
    ticks(4);
    check($sformatf("R3 sel %0d at threshold stays on", s), gate, 1);
    vds = 16'(go);
    tick();
    check($sformatf("R3 sel %0d above threshold off", s), gate, 0);
  endtask

  task automatic t_off_sel();
    off_case(2'd0, -7, -6);
    off_case(2'd1, -21, -20);
    off_case(2'd2, -38, -37);
    off_case(2'd3, -7, -6);
  endtask

  task automatic t_blank();
    int early;
    do_reset();
    mot = CW'(2);
    arm_and_fire();
    vds = 16'sd0;
    wait_gate_low();
    vds = -16'sd200;
    early = 0;
    for (int i = 0; i < BLK; i++) begin
      tick();
      if (gate) early++;
    end
    check("R5 no turn-on inside blanking", early, 0);
    tick();
    check("R5 turn-on after blanking", gate, 1);
  endtask

  task automatic t_rearm();
    do_reset();
    mot = CW'(2);
    arm_and_fire();
    vds = 16'sd0;
    wait_gate_low();
    vds = 16'sd5000;
    tick();
    vds = -16'sd200;
    tick();
    check("R6 reset level not exceeded", gate, 0);
    vds = 16'sd5001;
    tick();
    vds = -16'sd200;
    tick();
    check("R6 early re-arm", gate, 1);
  endtask

  task automatic t_uv();
    do_reset();
    mot = CW'(2);
    arm_and_fire();
    vsup = 8'd90;
    ticks(3);
    check("R8 supply at lower level keeps on", gate, 1);
    vsup = 8'd89;
    tick();
    check("R8 undervoltage off", gate, 0);
    vsup = 8'd100;
    ticks(3);
    check("R8 hysteresis holds lockout", gate, 0);
    vsup = 8'd106;
    tick();
    check("R8 re-arm cycle", gate, 0);
    tick();
    check("R8 fires after recovery", gate, 1);
  endtask

  task automatic t_sleep();
    do_reset();
    mot = CW'(2);
    arm_and_fire();
    en = 1'b0;
    tick();
    check("R9 sleep forces off", gate, 0);
    ticks(3);
    check("R9 no switching asleep", gate, 0);
    en = 1'b1;
    tick();
    check("R9 wake arms", gate, 0);
    tick();
    check("R9 fires after wake", gate, 1);
  endtask

  initial begin
    t_reset();
    t_lockout();
    t_turn_on();
    t_mot();
    t_off_sel();
    t_blank();
    t_rearm();
    t_uv();
    t_sleep();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule